// File: doc/BRIEF.md
# Digest Output Serializer

This block sits between a hash core and a narrow output bus. The core hands over a finished digest in one transfer. The core raises a valid flag, and the block answers with a one-cycle acknowledge at the moment it captures the digest. The block then sends the digest out one word at a time. It starts with the most significant bits.

Each word stays on the bus until the consumer acknowledges it, and a separate flag marks the final word. Once the final word is taken, the block goes back to idle and can accept the next digest. The digest width and the word width are parameters. When the digest is not a whole number of words, the word count is rounded up and the unused upper bits of the final word are driven to zero.

Top module: `digest_serializer`

## Requirements
- R1: While idle, a high `core_valid` at a clock edge captures `core_digest`. In the following cycle `core_ack` is high for exactly one cycle and `out_valid` rises.
- R2: While a digest is being sent, `core_valid` and `core_digest` are ignored. The words already captured are not changed, and `core_ack` stays low.
- R3: While `out_valid` is high and `out_ack` is low, `out_data`, `out_valid` and `out_last` hold their values.
- R4: One digest produces exactly ceil(DIGEST_W/WORD_W) accepted words. For example, a 216-bit digest on a 32-bit bus gives 7 words.
- R5: `out_last` is high only while `out_valid` is high and the final word of the digest is on the bus.
- R6: In the cycle after the final word is acknowledged, `out_valid` and `out_last` are low and the block accepts a new digest.
- R7: Word k (counting from 0) carries digest bits [DIGEST_W-1-k*WORD_W -: WORD_W] for every word except the final one, so the most significant word is sent first.
- R8: The final word carries the remaining low digest bits in its low bits, with all upper bits zero. For a 216-bit digest on a 32-bit bus, the final word is {8'h00, digest[23:0]}.
- R9: `out_ack` has no effect while `out_valid` is low.
- R10: While `rst` is high, `out_valid`, `out_last`, `core_ack` and `out_data` are all zero. A transfer in progress is abandoned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| core_digest | input | DIGEST_W | Digest from the hash core |
| core_valid | input | 1 | Digest present from the core |
| core_ack | output | 1 | One-cycle pulse when the digest is captured |
| out_data | output | WORD_W | Current output word |
| out_valid | output | 1 | Output word present |
| out_ack | input | 1 | Consumer has taken the current word |
| out_last | output | 1 | Current word is the final word of the digest |

## Verification
The assertions rely on the hash core dropping `core_valid` by the time it sees `core_ack`. If the core keeps it high, the block treats the next edge after a finished transfer as a new capture. The assertions also rely on the consumer driving `out_ack` only at the clock edges it intends to consume on. The stimulus keeps `core_valid` high during a transfer only when it sends deliberate noise to show that the input is ignored, and it lowers the signal before the final acknowledge. Acknowledge gaps are random from zero to three cycles, and acknowledges are also sent while idle.

// File: rtl/dser_pkg.sv
package dser_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_SEND = 1'b1
  } dser_state_e;

  // Number of bus words needed for a digest, rounded up.
  function automatic int unsigned words_for(input int unsigned digest_w,
                                            input int unsigned word_w);
    return (digest_w + word_w - 1) / word_w;
  endfunction

  // Width of a counter indexing n words (at least one bit).
  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // Number of genuine digest bits in the final word.
  function automatic int unsigned tail_bits(input int unsigned digest_w,
                                            input int unsigned word_w);
    return digest_w - (words_for(digest_w, word_w) - 1) * word_w;
  endfunction

endpackage

// File: rtl/dser_frame.sv
module dser_frame #(
  parameter int unsigned DIGEST_W = 224,
  parameter int unsigned WORD_W   = 32
) (
  input  logic [DIGEST_W-1:0]                                      digest,
  output logic [dser_pkg::words_for(DIGEST_W, WORD_W)*WORD_W-1:0]  frame
);
  localparam int unsigned NUM_WORDS = dser_pkg::words_for(DIGEST_W, WORD_W);
  localparam int unsigned TAIL_W    = dser_pkg::tail_bits(DIGEST_W, WORD_W);
  localparam int unsigned PAD_W     = WORD_W - TAIL_W;

  // Lay the digest out so that the final word is right-aligned and zero-filled.
  generate
    if (PAD_W == 0) begin : g_exact
      assign frame = digest;
    end else if (NUM_WORDS == 1) begin : g_single
      assign frame = {{PAD_W{1'b0}}, digest};
    end else begin : g_padded
      assign frame = {digest[DIGEST_W-1:TAIL_W], {PAD_W{1'b0}}, digest[TAIL_W-1:0]};
    end
  endgenerate

endmodule

// File: rtl/dser_shift.sv
module dser_shift #(
  parameter int unsigned WORD_W    = 32,
  parameter int unsigned NUM_WORDS = 7
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          load,
  input  logic                          advance,
  input  logic [NUM_WORDS*WORD_W-1:0]   frame_in,
  output logic [WORD_W-1:0]             word_out
);
  localparam int unsigned FRAME_W = NUM_WORDS * WORD_W;

  logic [FRAME_W-1:0] store_q;
  logic [FRAME_W-1:0] shifted;

  generate
    if (NUM_WORDS == 1) begin : g_one
      assign shifted = '0;
    end else begin : g_many
      assign shifted = {store_q[FRAME_W-WORD_W-1:0], {WORD_W{1'b0}}};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      store_q <= '0;
    end else if (load) begin
      store_q <= frame_in;
    end else if (advance) begin
      store_q <= shifted;
    end
  end

  assign word_out = store_q[FRAME_W-1 -: WORD_W];

endmodule

// File: rtl/dser_ctrl.sv
module dser_ctrl #(
  parameter int unsigned NUM_WORDS = 7
) (
  input  logic clk,
  input  logic rst,
  input  logic core_valid,
  input  logic out_ack,
  output logic load_evt,
  output logic advance_evt,
  output logic finish_evt,
  output logic core_ack,
  output logic out_valid,
  output logic out_last
);
  import dser_pkg::*;

  localparam int unsigned CNT_W = idx_width(NUM_WORDS);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(NUM_WORDS - 1);

  dser_state_e      state_q;
  logic [CNT_W-1:0] idx_q;
  logic             ack_q;
  logic             on_last;

  assign on_last     = (idx_q == LAST_IDX);
  assign load_evt    = (state_q == ST_IDLE) && core_valid;
  assign advance_evt = (state_q == ST_SEND) && out_ack;
  assign finish_evt  = advance_evt && on_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      ack_q   <= 1'b0;
    end else begin
      ack_q <= load_evt;
      if (load_evt) begin
        state_q <= ST_SEND;
        idx_q   <= '0;
      end else if (finish_evt) begin
        state_q <= ST_IDLE;
        idx_q   <= '0;
      end else if (advance_evt) begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  assign core_ack  = ack_q;
  assign out_valid = (state_q == ST_SEND);
  assign out_last  = (state_q == ST_SEND) && on_last;

endmodule

// File: rtl/digest_serializer.sv
module digest_serializer #(
  parameter int unsigned DIGEST_W = 224,
  parameter int unsigned WORD_W   = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [DIGEST_W-1:0] core_digest,
  input  logic                core_valid,
  output logic                core_ack,
  output logic [WORD_W-1:0]   out_data,
  output logic                out_valid,
  input  logic                out_ack,
  output logic                out_last
);
  localparam int unsigned NUM_WORDS = dser_pkg::words_for(DIGEST_W, WORD_W);
  localparam int unsigned FRAME_W   = NUM_WORDS * WORD_W;

  // Named internal events, visible to the bound checker.
  logic               load_evt;
  logic               advance_evt;
  logic               finish_evt;
  logic [FRAME_W-1:0] frame;

  dser_frame #(
    .DIGEST_W (DIGEST_W),
    .WORD_W   (WORD_W)
  ) u_frame (
    .digest (core_digest),
    .frame  (frame)
  );

  dser_ctrl #(
    .NUM_WORDS (NUM_WORDS)
  ) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .core_valid  (core_valid),
    .out_ack     (out_ack),
    .load_evt    (load_evt),
    .advance_evt (advance_evt),
    .finish_evt  (finish_evt),
    .core_ack    (core_ack),
    .out_valid   (out_valid),
    .out_last    (out_last)
  );

  dser_shift #(
    .WORD_W    (WORD_W),
    .NUM_WORDS (NUM_WORDS)
  ) u_shift (
    .clk      (clk),
    .rst      (rst),
    .load     (load_evt),
    .advance  (advance_evt),
    .frame_in (frame),
    .word_out (out_data)
  );

endmodule

// File: rtl/dser_checker.sv
module dser_checker #(
  parameter int unsigned WORD_W    = 32,
  parameter int unsigned NUM_WORDS = 7
) (
  input logic              clk,
  input logic              rst,
  input logic              core_valid,
  input logic              core_ack,
  input logic [WORD_W-1:0] out_data,
  input logic              out_valid,
  input logic              out_ack,
  input logic              out_last,
  input logic              load_evt,
  input logic              finish_evt
);
  // Independent count of words accepted in the current transfer.
  int unsigned taken_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      taken_q <= 0;
    end else if (out_valid && out_ack) begin
      if (out_last) taken_q <= 0;
      else          taken_q <= taken_q + 1;
    end
  end

  AST_LOAD_ACKS: assert property (@(posedge clk) disable iff (rst)
    load_evt |=> core_ack && out_valid);  // R1
  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (rst)
    core_ack |=> !core_ack);  // R1
  AST_ACK_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
    core_ack |-> $past(core_valid) && !$past(out_valid));  // R1
  AST_BUSY_NO_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !core_ack);  // R2
  AST_HOLD_WORD: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ack |=> out_valid && $stable(out_data) && $stable(out_last));  // R3
  AST_LAST_AT_COUNT: assert property (@(posedge clk) disable iff (rst)
    out_last |-> taken_q == NUM_WORDS - 1);  // R4
  AST_COUNT_GIVES_LAST: assert property (@(posedge clk) disable iff (rst)
    out_valid && taken_q == NUM_WORDS - 1 |-> out_last);  // R4
  AST_LAST_WITH_VALID: assert property (@(posedge clk) disable iff (rst)
    out_last |-> out_valid);  // R5
  AST_DONE_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
    finish_evt |=> !out_valid && !out_last);  // R6
  AST_IDLE_ACK_INERT: assert property (@(posedge clk) disable iff (rst)
    !out_valid && !core_valid |=> !out_valid);  // R9

endmodule

bind digest_serializer dser_checker #(
  .WORD_W    (WORD_W),
  .NUM_WORDS (NUM_WORDS)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .core_valid (core_valid),
  .core_ack   (core_ack),
  .out_data   (out_data),
  .out_valid  (out_valid),
  .out_ack    (out_ack),
  .out_last   (out_last),
  .load_evt   (load_evt),
  .finish_evt (finish_evt)
);

// File: tb/digest_serializer_tb.sv
module digest_serializer_tb;
  localparam int DW   = 216;
  localparam int WW   = 32;
  localparam int NW   = 7;
  localparam int TAIL = DW - (NW - 1) * WW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [DW-1:0] core_digest = '0;
  logic          core_valid = 1'b0;
  logic          core_ack;
  logic [WW-1:0] out_data;
  logic          out_valid;
  logic          out_ack = 1'b0;
  logic          out_last;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  digest_serializer #(.DIGEST_W(DW), .WORD_W(WW)) u_dut (
    .clk(clk), .rst(rst), .core_digest(core_digest), .core_valid(core_valid),
    .core_ack(core_ack), .out_data(out_data), .out_valid(out_valid),
    .out_ack(out_ack), .out_last(out_last));

  // Expected word k: top-down slices, final word holds low bits zero-extended.
  function automatic logic [WW-1:0] exp_word(input logic [DW-1:0] d, input int k);
    logic [DW-1:0] sh;
    logic [WW-1:0] w;
    if (k < NW - 1) begin
      sh = d >> (DW - (k + 1) * WW);
      w  = sh[WW-1:0];
    end else begin
      w = '0;
      for (int b = 0; b < TAIL; b++) w[b] = d[b];
    end
    return w;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [WW-1:0] act, input logic [WW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // Full transfer; noisy drives core_valid with another digest while busy.
  task automatic send(input logic [DW-1:0] d, input bit noisy);
    core_digest = d;
    core_valid  = 1'b1;
    tick();
    chk(core_ack == 1'b1, "R1", "core_ack after capture", WW'(core_ack), 1);
    chk(out_valid == 1'b1, "R1", "out_valid after capture", WW'(out_valid), 1);
    core_valid  = noisy;
    core_digest = ~d;
    tick();
    chk(core_ack == 1'b0, "R1", "core_ack single pulse", WW'(core_ack), 0);
    for (int k = 0; k < NW; k++) begin
      int gap;
      gap = $urandom_range(0, 3);
      for (int g = 0; g < gap; g++) begin
        chk(out_data == exp_word(d, k) && out_valid, "R3", "word held", out_data, exp_word(d, k));
        tick();
      end
      if (k == NW - 1) core_valid = 1'b0;
      chk(out_valid == 1'b1, "R4", "word present", WW'(out_valid), 1);
      if (k == NW - 1)
        chk(out_data == exp_word(d, k), "R8", "padded final word", out_data, exp_word(d, k));
      else
        chk(out_data == exp_word(d, k), noisy ? "R2" : "R7", "word order", out_data, exp_word(d, k));
      chk(out_last == (k == NW - 1), "R5", "last flag", WW'(out_last), WW'(k == NW - 1));
      out_ack = 1'b1;
      tick();
      out_ack = 1'b0;
    end
    chk(out_valid == 1'b0 && out_last == 1'b0, "R6", "idle after final", WW'({out_valid, out_last}), 0);
    chk(core_ack == 1'b0, "R2", "no capture while busy", WW'(core_ack), 0);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] d;
    void'($urandom(32'd4242));
    tick();
    tick();
    // R10: reset state
    chk(out_valid == 0 && out_last == 0 && core_ack == 0, "R10", "reset flags",
        WW'({out_valid, out_last, core_ack}), 0);
    chk(out_data == 0, "R10", "reset data", out_data, 0);
    rst = 1'b0;
    tick();

    // R9: acknowledges while idle do nothing
    out_ack = 1'b1;
    for (int i = 0; i < 3; i++) begin
      tick();
      chk(out_valid == 1'b0, "R9", "idle ack inert", WW'(out_valid), 0);
    end
    out_ack = 1'b0;

    // Directed corners
    send({DW{1'b1}}, 1'b0);
    send(DW'(1), 1'b0);
    d = '0;
    for (int i = 0; i < NW; i++) d = (d << WW) | DW'(32'h0102_0304 * (i + 1));
    send(d, 1'b1);

    // R10: reset mid-transfer
    core_digest = {DW{1'b1}};
    core_valid  = 1'b1;
    tick();
    core_valid = 1'b0;
    out_ack    = 1'b1;
    tick();
    tick();
    out_ack = 1'b0;
    rst     = 1'b1;
    tick();
    chk(out_valid == 0 && out_last == 0 && core_ack == 0 && out_data == 0, "R10",
        "mid-transfer reset", out_data, 0);
    rst = 1'b0;
    tick();

    // Random transfers
    for (int t = 0; t < 20; t++) begin
      d = '0;
      for (int i = 0; i < NW; i++) d = (d << WW) | DW'($urandom());
      send(d, t[0]);
      if ($urandom_range(0, 1) == 1) tick();
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule